// File: doc/BRIEF.md
# USART-Based SPI Master with Double-Buffered Transmit

This block is a serial port that runs only as an SPI master. Software reaches it through a small byte-wide register port. The port has a data register, a status register, an enable register, a format register and a clock divider register. A transmit byte written to the data register waits in a one-byte holding buffer. When the shifter is idle, the byte moves into the shifter. This lets software queue the next byte while the current one is still on the wire. The block generates the serial clock itself from the system clock. It shifts data out on `txd_o` and samples `rxd_i` at the same time. Each completed frame leaves the received byte in a receive buffer.

Two interrupt requests go to the surrounding system. One reports that the holding buffer can take a new byte. The other reports that all queued data has left the shifter. Both are qualified by a global interrupt enable input. Turning the transmitter off is deferred: the block keeps the TxD override and keeps shifting until nothing is left to send. Turning the receiver off discards the received byte. The transmitter owns the clock, so the receiver alone never starts a transfer.

Register map used throughout (8-bit registers, 3-bit address):

| Address | Register | Fields |
|---|---|---|
| 0 | DATA | write: transmit holding buffer; read: receive buffer (a read pops the receive flag) |
| 1 | STAT | bit0 buffer-empty (read-only), bit1 transmit-done (write 1 to clear), bit2 receive-full (read-only) |
| 2 | EN | bit0 transmit enable, bit1 receive enable, bit2 buffer-empty IRQ enable, bit3 transmit-done IRQ enable |
| 3 | FMT | bits7:6 mode (11 = SPI master), bit2 LSB-first, bit1 phase, bit0 idle clock level |
| 4 | DIV | half-period of the serial clock minus one, in system clocks |

Top module: `usart_spi_master`

## Requirements
- R1: After reset, STAT reads 0x01, EN, FMT and DIV read 0x00, and `sck_o`, `txd_oe_o`, `irq_dre_o` and `irq_tc_o` are all 0.
- R2: A transfer starts only while FMT bits 7:6 equal 11. With any other mode value a byte written to DATA stays in the holding buffer (STAT bit0 stays 0) and `sck_o` does not toggle.
- R3: A frame is 8 bits long and uses 16 serial clock half-periods of DIV+1 system clocks each. Outside a frame, `sck_o` equals FMT bit0.
- R4: With FMT bit1 = 0, `txd_o` presents a bit before the first clock edge of its bit period, and `rxd_i` is sampled on the first edge. With FMT bit1 = 1, `txd_o` changes on the first edge and `rxd_i` is sampled on the second edge. FMT bit2 = 1 sends and assembles bit 0 first, otherwise bit 7 first.
- R5: STAT bit0 rises when the held byte moves into the shifter. A byte written during a frame starts its own frame on the cycle after the current frame ends.
- R6: STAT bit1 is set when a frame ends while the holding buffer is empty. It is cleared by writing 1 to STAT bit1 or by pulsing `tc_ack_i`.
- R7: `irq_tc_o` is 1 exactly when EN bit3, `gie_i` and STAT bit1 are all 1.
- R8: `irq_dre_o` is 1 exactly when EN bit2, `gie_i` and STAT bit0 are all 1.
- R9: `txd_oe_o` is 1 while the transmitter is enabled. After EN bit0 is cleared, `txd_oe_o` and shifting continue until both the shifter and the holding buffer are empty.
- R10: With EN bit1 set and the transmitter disabled, no frame starts and `sck_o` stays at its idle level.
- R11: At the end of each frame with the receiver enabled, the received byte is loaded into DATA and STAT bit2 is set. A read of DATA clears STAT bit2.
- R12: While EN bit1 is 0, the receive buffer reads 0x00 and STAT bit2 reads 0.
- R13: Reserved bits read as zero: EN bits 7:4 and FMT bits 5:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops receive flag on DATA) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational on addr_i) |
| gie_i | input | 1 | Global interrupt enable |
| tc_ack_i | input | 1 | Acknowledge of the transmit-done interrupt |
| sck_o | output | 1 | Serial clock |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| txd_oe_o | output | 1 | TxD pin override enable |
| irq_dre_o | output | 1 | Buffer-empty interrupt request |
| irq_tc_o | output | 1 | Transmit-done interrupt request |

## Verification
Some internal faults show at the serial pins within one half-period of the serial clock: a wrong half-period count, a stale phase or order setting, or a divider that does not restart. They show as a misplaced `sck_o` edge or a wrong `txd_o` level, so the per-cycle comparison catches them at once. A holding-buffer or flag fault shows on `irq_dre_o`/`irq_tc_o` in the same cycle the flag goes wrong, provided the interrupt enables and `gie_i` are on. Otherwise it shows at the next STAT read. A sampling fault is visible only at the end of a frame, when the byte read back from DATA differs from the pattern the bench drove on `rxd_i`.

// File: rtl/usart_spi_pkg.sv
package usart_spi_pkg;

    localparam int REG_W      = 8;
    localparam int FRAME_BITS = REG_W;
    localparam int HALF_W     = $clog2(2 * FRAME_BITS);
    localparam int IDX_W      = HALF_W - 1;
    localparam int DIV_W      = REG_W;
    localparam int ADDR_W     = 3;
    localparam int EN_W       = 4;

    localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * FRAME_BITS - 1);

    // register addresses
    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_FMT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

    // STAT bits
    localparam int B_DRE = 0;
    localparam int B_TC  = 1;
    localparam int B_RXF = 2;
    // EN bits
    localparam int B_TXEN  = 0;
    localparam int B_RXEN  = 1;
    localparam int B_DREIE = 2;
    localparam int B_TCIE  = 3;
    // FMT bits
    localparam int B_CPOL = 0;
    localparam int B_CPHA = 1;
    localparam int B_LSB  = 2;
    localparam int B_MLO  = 6;
    localparam int B_MHI  = 7;

    localparam logic [1:0]       MODE_SPI = 2'b11;
    localparam logic [REG_W-1:0] FMT_MASK = 8'hC7;

    typedef logic [FRAME_BITS-1:0] word_t;

    typedef struct packed {
        logic              busy;
        logic [HALF_W-1:0] half;
        logic              sck;
        logic              txd;
        logic              cpol;
        logic              cpha;
        logic              lsb;
        word_t             tx_sr;
        word_t             rx_sr;
    } eng_state_t;

    typedef struct packed {
        logic             buf_full;
        word_t            buf_data;
        logic             tx_act;
        logic             tc;
        logic             rxf;
        word_t            rx_buf;
        logic [EN_W-1:0]  en;
        logic [REG_W-1:0] fmt;
        logic [DIV_W-1:0] div;
    } ctl_state_t;

    function automatic word_t flip(word_t v);
        word_t r;
        for (int i = 0; i < FRAME_BITS; i++) r[i] = v[FRAME_BITS-1-i];
        return r;
    endfunction

endpackage

// File: rtl/usart_spi_baud.sv
module usart_spi_baud
    import usart_spi_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        if (!run_i)      cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R3: a running divider never starts a half-period with a stale count
    p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_i) |-> cnt_q == '0);

endmodule

// File: rtl/usart_spi_engine.sv
module usart_spi_engine
    import usart_spi_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  start_i,
    input  word_t data_i,
    input  logic  cpol_i,
    input  logic  cpha_i,
    input  logic  lsb_i,
    input  logic  tick_i,
    input  logic  rxd_i,
    output logic  busy_o,
    output logic  sck_o,
    output logic  txd_o,
    output logic  done_o,
    output word_t rx_data_o
);

    eng_state_t q, nx;
    logic [IDX_W-1:0] bit_i;

    always_comb begin
        nx     = q;
        done_o = 1'b0;
        bit_i  = q.half[HALF_W-1:1];
        if (start_i && !q.busy) begin
            nx.busy  = 1'b1;
            nx.half  = '0;
            nx.sck   = cpol_i;
            nx.cpol  = cpol_i;
            nx.cpha  = cpha_i;
            nx.lsb   = lsb_i;
            nx.tx_sr = lsb_i ? flip(data_i) : data_i;
            nx.rx_sr = '0;
            if (!cpha_i) nx.txd = nx.tx_sr[FRAME_BITS-1];
        end else if (q.busy && tick_i) begin
            nx.sck  = ~q.sck;
            nx.half = q.half + 1'b1;
            if (!q.half[0]) begin
                // leading edge of a bit period
                if (q.cpha) nx.txd = q.tx_sr[IDX_W'(FRAME_BITS-1) - bit_i];
                else        nx.rx_sr = {q.rx_sr[FRAME_BITS-2:0], rxd_i};
            end else begin
                // trailing edge of a bit period
                if (q.cpha) nx.rx_sr = {q.rx_sr[FRAME_BITS-2:0], rxd_i};
                else if (q.half != LAST_HALF)
                    nx.txd = q.tx_sr[IDX_W'(FRAME_BITS-2) - bit_i];
            end
            if (q.half == LAST_HALF) begin
                nx.busy = 1'b0;
                done_o  = 1'b1;
            end
        end
        rx_data_o = nx.lsb ? flip(nx.rx_sr) : nx.rx_sr;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= nx;
    end

    assign busy_o = q.busy;
    assign sck_o  = q.busy ? q.sck : cpol_i;
    assign txd_o  = q.txd;

    // R3: after sixteen toggles the clock is back at the latched idle level
    p_idle_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.busy) |-> (q.sck == q.cpol));

    // R5: a new frame is never accepted on top of a running one
    p_no_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.busy && !tick_i) |=> $stable(q.tx_sr));

endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master
    import usart_spi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              gie_i,
    input  logic              tc_ack_i,
    output logic              sck_o,
    output logic              txd_o,
    input  logic              rxd_i,
    output logic              txd_oe_o,
    output logic              irq_dre_o,
    output logic              irq_tc_o
);

    ctl_state_t q, nx;
    logic  eng_busy, eng_done, tick, start;
    word_t eng_rx;
    logic  wr_data, wr_stat, wr_en_reg, rd_data;

    assign wr_data   = wr_en_i && (addr_i == A_DATA);
    assign wr_stat   = wr_en_i && (addr_i == A_STAT);
    assign wr_en_reg = wr_en_i && (addr_i == A_EN);
    assign rd_data   = rd_en_i && (addr_i == A_DATA);
    assign start     = q.tx_act && (q.fmt[B_MHI:B_MLO] == MODE_SPI)
                       && q.buf_full && !eng_busy;

    usart_spi_baud u_baud (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (eng_busy),
        .div_i  (q.div),
        .tick_o (tick)
    );

    usart_spi_engine u_eng (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .data_i    (q.buf_data),
        .cpol_i    (q.fmt[B_CPOL]),
        .cpha_i    (q.fmt[B_CPHA]),
        .lsb_i     (q.fmt[B_LSB]),
        .tick_i    (tick),
        .rxd_i     (rxd_i),
        .busy_o    (eng_busy),
        .sck_o     (sck_o),
        .txd_o     (txd_o),
        .done_o    (eng_done),
        .rx_data_o (eng_rx)
    );

    always_comb begin
        nx = q;
        if (wr_en_i) begin
            case (addr_i)
                A_EN:    nx.en  = wdata_i[EN_W-1:0];
                A_FMT:   nx.fmt = wdata_i & FMT_MASK;
                A_DIV:   nx.div = DIV_W'(wdata_i);
                default: ;
            endcase
        end
        // holding buffer
        if (start) nx.buf_full = 1'b0;
        if (wr_data) begin
            nx.buf_full = 1'b1;
            nx.buf_data = wdata_i;
        end
        // transmitter activity, disable deferred until drained
        if (wr_en_reg && wdata_i[B_TXEN])
            nx.tx_act = 1'b1;
        else if (!q.en[B_TXEN] && !q.buf_full && !eng_busy)
            nx.tx_act = 1'b0;
        // transmit-done flag, set wins
        if ((wr_stat && wdata_i[B_TC]) || tc_ack_i) nx.tc = 1'b0;
        if (eng_done && !q.buf_full)                nx.tc = 1'b1;
        // receive buffer
        if (!nx.en[B_RXEN]) begin
            nx.rxf    = 1'b0;
            nx.rx_buf = '0;
        end else begin
            if (rd_data) nx.rxf = 1'b0;
            if (eng_done) begin
                nx.rxf    = 1'b1;
                nx.rx_buf = eng_rx;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= nx;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_DATA: rdata_o = q.rx_buf;
            A_STAT: begin
                rdata_o[B_DRE] = !q.buf_full;
                rdata_o[B_TC]  = q.tc;
                rdata_o[B_RXF] = q.rxf;
            end
            A_EN:    rdata_o[EN_W-1:0] = q.en;
            A_FMT:   rdata_o = q.fmt;
            A_DIV:   rdata_o = REG_W'(q.div);
            default: ;
        endcase
    end

    assign txd_oe_o  = q.tx_act;
    assign irq_dre_o = q.en[B_DREIE] && gie_i && !q.buf_full;
    assign irq_tc_o  = q.en[B_TCIE] && gie_i && q.tc;

    // R2: the shifter only starts out of SPI master mode
    p_mode_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(eng_busy) |-> ($past(q.fmt[B_MHI:B_MLO]) == MODE_SPI));

    // R6: transmit-done only rises at a frame end
    p_tc_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.tc) |-> $past(eng_done));

    // R9: override released only once fully drained and disabled
    p_oe_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.tx_act) |-> $past(!eng_busy && !q.buf_full && !q.en[B_TXEN]));

    // R10: no clock activity without the transmitter
    p_clock_owner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q.tx_act |-> !eng_busy);

    // R12: disabled receiver holds nothing
    p_flush_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q.en[B_RXEN] |-> (!q.rxf && q.rx_buf == '0));

endmodule

// File: tb/usart_spi_master_test.sv
`timescale 1ns/1ps
module usart_spi_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       gie = 1'b0, ack = 1'b0, rxd = 1'b0;
    logic       sck_o, txd_o, txd_oe_o, irq_dre_o, irq_tc_o;

    always #2 clk = ~clk;

    usart_spi_master uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .gie_i(gie),
        .tc_ack_i(ack), .sck_o(sck_o), .txd_o(txd_o), .rxd_i(rxd),
        .txd_oe_o(txd_oe_o), .irq_dre_o(irq_dre_o), .irq_tc_o(irq_tc_o)
    );

    int checks = 0, failures = 0;
    bit fin = 1'b0;
    logic [7:0] pat = 8'h00;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rev(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // behavioural reference model
    bit m_full, m_busy, m_sck, m_txd, m_act, m_tc, m_cpha, m_lsb;
    logic [7:0] m_buf, m_word, m_fmt, m_div, m_cnt;
    logic [3:0] m_en;
    int m_k;

    always @(posedge clk) begin : model
        bit tick, dn, st, o_full, o_busy;
        int h, idx;
        logic [7:0] pw;
        if (!rst_n) begin
            m_full = 0; m_busy = 0; m_sck = 0; m_txd = 0; m_act = 0; m_tc = 0;
            m_cpha = 0; m_lsb = 0; m_buf = 0; m_word = 0; m_fmt = 0; m_div = 0;
            m_cnt = 0; m_en = 0; m_k = 0;
            rxd <= 1'b0;
        end else begin
            o_full = m_full; o_busy = m_busy;
            tick = m_busy && (m_cnt == m_div);
            dn   = tick && (m_k == 15);
            st   = m_act && (m_fmt[7:6] == 2'b11) && m_full && !m_busy;
            if (wr_en && addr == 3'd2 && wdata[0]) m_act = 1;
            else if (!m_en[0] && !o_full && !o_busy) m_act = 0;
            if (st) begin
                m_busy = 1; m_k = 0; m_cnt = 0;
                m_cpha = m_fmt[1]; m_lsb = m_fmt[2]; m_sck = m_fmt[0];
                m_word = m_lsb ? rev(m_buf) : m_buf;
                if (!m_cpha) m_txd = m_word[7];
                m_full = 0;
            end else if (m_busy) begin
                m_cnt = tick ? 8'd0 : m_cnt + 8'd1;
                if (tick) begin
                    h = m_k;
                    m_sck = !m_sck;
                    if (h % 2 == 0 && m_cpha) m_txd = m_word[7 - h/2];
                    if (h % 2 == 1 && !m_cpha && h != 15) m_txd = m_word[7 - (h+1)/2];
                    m_k++;
                    if (h == 15) m_busy = 0;
                end
            end
            if (wr_en && addr == 3'd0) begin m_full = 1; m_buf = wdata; end
            if ((wr_en && addr == 3'd1 && wdata[1]) || ack) m_tc = 0;
            if (dn && !o_full) m_tc = 1;
            if (wr_en) begin
                case (addr)
                    3'd2: m_en  = wdata[3:0];
                    3'd3: m_fmt = wdata & 8'hC7;
                    3'd4: m_div = wdata;
                    default: ;
                endcase
            end
            idx = m_cpha ? ((m_k == 0) ? 0 : (m_k - 1) / 2) : m_k / 2;
            if (idx > 7) idx = 7;
            pw = m_lsb ? rev(pat) : pat;
            rxd <= pw[7 - idx];
        end
    end

    // per-cycle comparison against the model
    initial forever begin
        @(posedge clk); #1;
        if (rst_n && !fin) begin
            chk("R3 sck_o", sck_o, m_busy ? m_sck : m_fmt[0]);
            chk("R4 txd_o", txd_o, m_txd);
            chk("R9 txd_oe_o", txd_oe_o, m_act);
            chk("R8 irq_dre_o", irq_dre_o, m_en[2] & gie & !m_full);
            chk("R7 irq_tc_o", irq_tc_o, m_en[3] & gie & m_tc);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 chk(tag, rdata, e);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, 8'h01, "R1 stat");
        rd(3'd2, 8'h00, "R1 en");
        rd(3'd3, 8'h00, "R1 fmt");
        rd(3'd4, 8'h00, "R1 div");
        chk("R1 sck", sck_o, 0);
        chk("R1 oe", txd_oe_o, 0);
        chk("R1 irq", {irq_dre_o, irq_tc_o}, 0);

        // R13 reserved bits
        wr(3'd2, 8'hF0); rd(3'd2, 8'h00, "R13 en");
        wr(3'd3, 8'h38); rd(3'd3, 8'h00, "R13 fmt");
        wr(3'd3, 8'hFF); rd(3'd3, 8'hC7, "R13 fmt ones");
        wr(3'd3, 8'h00);

        // R2 mode gate
        wr(3'd3, 8'h80); wr(3'd2, 8'h01); wr(3'd0, 8'h5A);
        idle(60); rd(3'd1, 8'h00, "R2 mode10 held");
        wr(3'd3, 8'h40); idle(30); rd(3'd1, 8'h00, "R2 mode01 held");
        wr(3'd3, 8'hC0); idle(40);
        rd(3'd1, 8'h03, "R6 done set");

        // R6 clear paths
        wr(3'd1, 8'h02); rd(3'd1, 8'h01, "R6 w1c");
        wr(3'd0, 8'h11); idle(40); rd(3'd1, 8'h03, "R6 set again");
        @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
        rd(3'd1, 8'h01, "R6 ack");

        // R4 / R11 all format combinations with receive
        wr(3'd2, 8'h03); wr(3'd4, 8'h02);
        for (int m = 0; m < 8; m++) begin
            wr(3'd3, 8'hC0 | 8'(m));
            pat = 8'h96 ^ 8'(m * 29);
            wr(3'd0, ~pat ^ 8'(m));
            idle(58);
            rd(3'd1, 8'h07, "R11 rx full");
            rd(3'd0, pat, "R4 rx byte");
            rd(3'd1, 8'h03, "R11 read pops");
            wr(3'd1, 8'h02);
        end

        // R5 double buffering
        wr(3'd3, 8'hC0); pat = 8'h3E;
        wr(3'd0, 8'hA1); wr(3'd0, 8'hB2);
        rd(3'd1, 8'h00, "R5 second byte held");
        idle(60); rd(3'd1, 8'h05, "R5 second frame running");
        idle(60); rd(3'd1, 8'h07, "R5 both done");

        // R7 / R8 interrupt gating
        wr(3'd1, 8'h02); rd(3'd0, 8'h3E, "R5 rx byte");
        wr(3'd2, 8'h0F);
        @(negedge clk); gie = 1'b0; #1 chk("R8 gie low", irq_dre_o, 0);
        @(negedge clk); gie = 1'b1; #1 chk("R8 gie high", irq_dre_o, 1);
        chk("R7 idle", irq_tc_o, 0);
        wr(3'd0, 8'h81); idle(60);
        #1 chk("R7 done", irq_tc_o, 1);
        @(negedge clk); gie = 1'b0; #1 chk("R7 gie low", irq_tc_o, 0);
        @(negedge clk); gie = 1'b1;
        wr(3'd2, 8'h07); #1 chk("R7 ie off", irq_tc_o, 0);
        chk("R8 ie on", irq_dre_o, 1);

        // R9 deferred transmit disable
        wr(3'd1, 8'h02); rd(3'd0, 8'h3E, "R11 rx byte");
        wr(3'd2, 8'h03); wr(3'd0, 8'h77); idle(5);
        wr(3'd2, 8'h02); #1 chk("R9 oe held", txd_oe_o, 1);
        idle(60); #1 chk("R9 oe released", txd_oe_o, 0);
        rd(3'd1, 8'h07, "R9 frame completed");

        // R10 receiver alone
        rd(3'd0, 8'h3E, "R11 rx byte 2");
        wr(3'd1, 8'h02); wr(3'd0, 8'h3C);
        begin
            logic prev;
            int tg;
            prev = sck_o; tg = 0;
            repeat (60) begin
                @(negedge clk);
                if (sck_o !== prev) tg++;
                prev = sck_o;
            end
            chk("R10 sck toggles", tg, 0);
        end
        rd(3'd1, 8'h00, "R10 no transfer");
        chk("R10 oe", txd_oe_o, 0);

        // R12 receive flush
        pat = 8'hE4;
        wr(3'd2, 8'h03); idle(60);
        rd(3'd1, 8'h07, "R11 frame in");
        wr(3'd2, 8'h01); wr(3'd2, 8'h03);
        rd(3'd1, 8'h03, "R12 flag flushed");
        rd(3'd0, 8'h00, "R12 data flushed");

        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule